// File: doc/BRIEF.md
# Level-Sensitive Processor Interrupt Gate

This block is the interrupt front end of a small RISC core. It takes a bank of level-sensitive request lines and masks each one with a bit of a per-line enable register. The result is a read-only pending view. A global enable bit in a small status register then gates the OR of all pending bits into the single interrupt request that goes to the core. Nothing is latched. A request that drops before the core reaches it leaves no pending bit behind.

A simple register port gives access to four registers, selected by a 2-bit address:

| Address | Register |
|---|---|
| 0 | status |
| 1 | saved status |
| 2 | enable |
| 3 | pending (read-only) |

An exception-entry strobe copies the status register into the saved-status register and clears the global enable. An exception-return strobe copies the saved value back into status.

At entry the block also records whether the exception was caused by a hardware interrupt. It is an interrupt only when the global enable was set and at least one pending bit was present. A request that vanished before entry is therefore classified as not an interrupt: this is the spurious case.

Top module: `irq_gate_top`

## Requirements
- R1: While reset is asserted and after it is released, status, saved status and enable all read zero, `irq_to_core` is 0 and `exc_is_irq` is 0.
- R2: Reading address 3 returns `irq_lines & enable` in the same cycle. There is no capture, so a line that drops clears its pending bit at once.
- R3: A write to address 3 is ignored: the enable register and the status register keep their values.
- R4: `irq_to_core` is 1 in the cycle after a clock edge at which the global enable (status bit 0) was 1 and some pending bit was 1; otherwise it is 0.
- R5: With the global enable at 0, `irq_to_core` stays 0 whatever the request and enable values are.
- R6: An `exc_enter` pulse copies all status bits into saved status and clears status bit 0, leaving the other status bits unchanged.
- R7: An `exc_return` pulse loads status from saved status.
- R8: At an `exc_enter` edge, `exc_is_irq` takes the value (global enable AND pending nonzero) and holds it until the next entry. A request that drops before entry gives 0.
- R9: In one cycle, `exc_enter` has priority over `exc_return`, and both have priority over a software write to status. A software write to saved status is dropped in a cycle with `exc_enter`.
- R10: Register writes take effect on the next clock edge. Status and saved status hold STAT_W low bits, and their upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| irq_lines | input | NUM_IRQ | Level-sensitive interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 saved status, 2 enable, 3 pending |
| reg_wdata | input | NUM_IRQ | Write data |
| reg_rdata | output | NUM_IRQ | Read data for `reg_addr`, combinational |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_return | input | 1 | Exception-return strobe |
| irq_to_core | output | 1 | Registered interrupt request to the core |
| exc_is_irq | output | 1 | Classification of the last taken exception |

## Verification
Each result has its own due time:
- Register reads are combinational. The pending value is compared in the same cycle as the request levels that produce it.
- Writes and the entry/return strobes change stored state at the next edge.
- `irq_to_core` and `exc_is_irq` reflect the state just before an edge and appear just after it.

Every table vector therefore drives its inputs at the falling edge and lets one rising edge pass. It then removes the strobes, selects the register to inspect and compares a few nanoseconds later. The request lines are held steady through the comparison, so the pending read and the registered outputs are judged against values worked out for that single edge.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  // Register select encoding; the order is fixed by software.
  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_SAVED   = 2'd1,
    SEL_ENABLE  = 2'd2,
    SEL_PENDING = 2'd3
  } reg_sel_e;

  // Bit of the status register that acts as the global enable.
  localparam int GIE_POS = 0;

endpackage

// File: rtl/irq_line_mask.sv
module irq_line_mask #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] lines_i,
  input  logic               en_wr_i,
  input  logic [NUM_IRQ-1:0] en_wdata_i,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic               any_pend_o
);

  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] en_d;

  // Next-state for the enable register.
  always_comb begin
    en_d = en_q;
    if (en_wr_i) en_d = en_wdata_i;
  end

  // Register with an explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= en_d;
  end

  // One gate per line; levels pass straight through, nothing is held.
  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_gate
      assign pending_o[g] = lines_i[g] & en_q[g];
    end
  endgenerate

  assign any_pend_o = |pending_o;
  assign enable_o   = en_q;

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_q));

endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl #(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_enter_i,
  input  logic              exc_return_i,
  input  logic              stat_wr_i,
  input  logic              saved_wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] saved_o,
  output logic              gie_o
);
  import irq_gate_pkg::*;

  localparam logic [STAT_W-1:0] GIE_MASK = STAT_W'(1) << GIE_POS;

  logic [STAT_W-1:0] status_q, status_d;
  logic [STAT_W-1:0] saved_q,  saved_d;
  logic              status_ce, saved_ce;

  // Next-state: entry beats return, and both beat software writes.
  always_comb begin
    status_d = status_q;
    saved_d  = saved_q;
    if (exc_enter_i) begin
      saved_d  = status_q;
      status_d = status_q & ~GIE_MASK;
    end else begin
      if (exc_return_i)   status_d = saved_q;
      else if (stat_wr_i) status_d = wdata_i;
      if (saved_wr_i)     saved_d  = wdata_i;
    end
  end

  assign status_ce = exc_enter_i | exc_return_i | stat_wr_i;
  assign saved_ce  = exc_enter_i | saved_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_ce) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        saved_q <= '0;
    else if (saved_ce) saved_q <= saved_d;
  end

  assign status_o = status_q;
  assign saved_o  = saved_q;
  assign gie_o    = status_q[GIE_POS];

  // R6
  enter_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter_i |=> !gie_o);
  // R6
  enter_saves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter_i |=> saved_q == $past(status_q));
  // R7
  return_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return_i && !exc_enter_i) |=> status_q == $past(saved_q));

endmodule

// File: rtl/irq_req_out.sv
module irq_req_out (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend_i,
  input  logic gie_i,
  input  logic exc_enter_i,
  output logic irq_o,
  output logic is_irq_o
);

  logic irq_q, irq_d;
  logic cls_q, cls_d;
  logic live;

  assign live = any_pend_i & gie_i;

  // Next-state.
  always_comb begin
    irq_d = live;
    cls_d = cls_q;
    if (exc_enter_i) cls_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cls_q <= 1'b0;
    else if (exc_enter_i) cls_q <= cls_d;
  end

  assign irq_o    = irq_q;
  assign is_irq_o = cls_q;

  // R5
  gie_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !irq_o);
  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && any_pend_i) |=> irq_o);
  // R8
  spurious_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter_i && !any_pend_i) |=> !is_irq_o);
  // R8
  cls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_enter_i |=> $stable(is_irq_o));

endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top #(
  parameter int NUM_IRQ = 32,
  parameter int STAT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_IRQ-1:0] reg_wdata,
  output logic [NUM_IRQ-1:0] reg_rdata,
  input  logic               exc_enter,
  input  logic               exc_return,
  output logic               irq_to_core,
  output logic               exc_is_irq
);
  import irq_gate_pkg::*;

  localparam int PAD_W = NUM_IRQ - STAT_W;

  reg_sel_e           sel;
  logic               stat_wr, saved_wr, en_wr;
  logic [NUM_IRQ-1:0] enable, pending;
  logic               any_pend, gie;
  logic [STAT_W-1:0]  status, saved;

  assign sel      = reg_sel_e'(reg_addr);
  assign stat_wr  = reg_wr && (sel == SEL_STATUS);
  assign saved_wr = reg_wr && (sel == SEL_SAVED);
  assign en_wr    = reg_wr && (sel == SEL_ENABLE);
  // A write to SEL_PENDING decodes to nothing.

  irq_line_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .lines_i    (irq_lines),
    .en_wr_i    (en_wr),
    .en_wdata_i (reg_wdata),
    .enable_o   (enable),
    .pending_o  (pending),
    .any_pend_o (any_pend)
  );

  irq_status_ctl #(.STAT_W(STAT_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_enter_i  (exc_enter),
    .exc_return_i (exc_return),
    .stat_wr_i    (stat_wr),
    .saved_wr_i   (saved_wr),
    .wdata_i      (reg_wdata[STAT_W-1:0]),
    .status_o     (status),
    .saved_o      (saved),
    .gie_o        (gie)
  );

  irq_req_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_pend_i  (any_pend),
    .gie_i       (gie),
    .exc_enter_i (exc_enter),
    .irq_o       (irq_to_core),
    .is_irq_o    (exc_is_irq)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS:  reg_rdata = {{PAD_W{1'b0}}, status};
      SEL_SAVED:   reg_rdata = {{PAD_W{1'b0}}, saved};
      SEL_ENABLE:  reg_rdata = enable;
      SEL_PENDING: reg_rdata = pending;
      default:     reg_rdata = '0;
    endcase
  end

  // R3
  pend_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_PENDING && !exc_enter && !exc_return)
      |=> ($stable(enable) && $stable(status)));

endmodule

// File: tb/tb_irq_gate_top.sv
module tb_irq_gate_top;

  localparam int N  = 32;
  localparam int NV = 16;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] irq_lines;
  logic         reg_wr;
  logic [1:0]   reg_addr;
  logic [N-1:0] reg_wdata;
  logic [N-1:0] reg_rdata;
  logic         exc_enter, exc_return;
  logic         irq_to_core, exc_is_irq;

  int n_chk = 0;
  int n_bad = 0;

  irq_gate_top #(.NUM_IRQ(N), .STAT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .exc_enter(exc_enter), .exc_return(exc_return),
    .irq_to_core(irq_to_core), .exc_is_irq(exc_is_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // Vector: wr, addr, wdata, lines, enter, ret, chk_addr, exp_rdata, exp_irq, exp_cls
  localparam logic [104:0] VEC [NV] = '{
    {1'b1,2'd2,32'h0000_00F0,32'h0,1'b0,1'b0,2'd2,32'h0000_00F0,1'b0,1'b0}, // R10 enable write
    {1'b1,2'd0,32'h0000_0001,32'h10,1'b0,1'b0,2'd0,32'h1,1'b0,1'b0},       // R10 gie set
    {1'b0,2'd0,32'h0,32'h10,1'b0,1'b0,2'd3,32'h10,1'b1,1'b0},              // R4 R2
    {1'b0,2'd0,32'h0,32'h0,1'b0,1'b0,2'd3,32'h0,1'b0,1'b0},                // R2 drop, no latch
    {1'b1,2'd3,32'hFFFF_FFFF,32'h01,1'b0,1'b0,2'd2,32'h0000_00F0,1'b0,1'b0}, // R3
    {1'b0,2'd0,32'h0,32'h20,1'b1,1'b0,2'd1,32'h1,1'b1,1'b1},               // R6 R8
    {1'b0,2'd0,32'h0,32'h20,1'b0,1'b0,2'd0,32'h0,1'b0,1'b1},               // R5 R6
    {1'b0,2'd0,32'h0,32'h20,1'b0,1'b1,2'd0,32'h1,1'b0,1'b1},               // R7
    {1'b0,2'd0,32'h0,32'h20,1'b0,1'b0,2'd3,32'h20,1'b1,1'b1},              // R4
    {1'b0,2'd0,32'h0,32'h0,1'b1,1'b0,2'd0,32'h0,1'b0,1'b0},                // R8 spurious
    {1'b1,2'd0,32'h0000_000E,32'h0,1'b0,1'b1,2'd0,32'h1,1'b0,1'b0},        // R9 return beats write
    {1'b1,2'd0,32'h0000_000F,32'h0,1'b0,1'b0,2'd0,32'hF,1'b0,1'b0},        // R10
    {1'b1,2'd0,32'h0,32'h80,1'b1,1'b1,2'd1,32'hF,1'b1,1'b1},               // R9 entry wins
    {1'b0,2'd0,32'h0,32'h80,1'b0,1'b0,2'd0,32'hE,1'b0,1'b1},               // R6 other bits kept
    {1'b1,2'd0,32'hFFFF_FFF1,32'h80,1'b0,1'b0,2'd0,32'h1,1'b0,1'b1},       // R10 upper bits zero
    {1'b1,2'd1,32'h0000_0003,32'h80,1'b0,1'b0,2'd1,32'h3,1'b1,1'b1}        // R10 saved write
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    exc_enter = 1'b0; exc_return = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state(input string tag);
    reg_addr = 2'd0; #1; check({tag, " R1 status"}, reg_rdata, '0);
    reg_addr = 2'd1; #1; check({tag, " R1 saved"},  reg_rdata, '0);
    reg_addr = 2'd2; #1; check({tag, " R1 enable"}, reg_rdata, '0);
    check({tag, " R1 irq"}, {31'b0, irq_to_core}, '0);
    check({tag, " R1 cls"}, {31'b0, exc_is_irq},  '0);
  endtask

  // Watchdog: an expiry counts as a miscompare and still reports.
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    irq_lines = '0;
    do_reset();
    check_reset_state("post-reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr     = VEC[i][104];
      reg_addr   = VEC[i][103:102];
      reg_wdata  = VEC[i][101:70];
      irq_lines  = VEC[i][69:38];
      exc_enter  = VEC[i][37];
      exc_return = VEC[i][36];
      @(posedge clk);
      #2;
      reg_wr = 1'b0; exc_enter = 1'b0; exc_return = 1'b0;
      reg_addr = VEC[i][35:34];
      #3;
      check($sformatf("vec%0d rdata", i), reg_rdata, VEC[i][33:2]);
      check($sformatf("vec%0d irq R4/R5", i), {31'b0, irq_to_core}, {31'b0, VEC[i][1]});
      check($sformatf("vec%0d cls R8", i), {31'b0, exc_is_irq}, {31'b0, VEC[i][0]});
    end

    // R5: global enable off, every line requested and enabled.
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = '1; irq_lines = '1;
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = '0;
    @(negedge clk);
    idle();
    repeat (3) begin
      @(negedge clk);
      check("R5 masked all", {31'b0, irq_to_core}, '0);
    end
    reg_addr = 2'd3; #1;
    check("R2 full pending", reg_rdata, '1);

    // R1: reset in the middle of activity, with the outputs high before it.
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1;
    @(negedge clk);
    exc_enter = 1'b1; reg_wr = 1'b0;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #2;
    check_reset_state("in-reset");
    @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("re-reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule